// File: doc/BRIEF.md
# Dual-Path ADC Result Comparator

This block cross-checks a multi-channel primary ADC against a secondary ADC, one channel per run. The host picks a channel, confirms that the secondary input selector is held on that single channel, and pulses `start`. The block then waits out a programmable settling interval. During that interval the secondary path's anti-alias filter settles, so a longer interval buys less noise at the cost of diagnostic time. After settling, the block waits for a primary-sample slot that serves as the alignment mark. It then captures one prefiltered primary result for the chosen channel and one secondary result, and judges their signed difference against a host tolerance.

Both ADC streams arrive as strobed samples. Each primary sample carries a slot index. Slots 0 to 15 are the measurement channels. Slot 16 carries the current-sense input pair, which is never part of this comparison. The alignment mark is slot 0 by default and slot 7 when the late-alignment control is set. The late setting narrows the time gap between the two paths for the upper channels.

A start with an unusable setup does not run. Instead the block writes a defined abort pattern at once: both ready flags are set, the abort flag is set, every fault bit is set, and the secondary capture register is forced to its empty value.

Top module: `adc_xcheck`

## Requirements
- R1: After reset, `pri_cap` and `sec_cap` hold 0x8000 (top bit set, all others clear), `flt_vec` is zero, and `rdy_sec`, `rdy_cmp` and `abort_flg` are 0.
- R2: A `start` pulse while idle, with `adc_run`=1, `sel_single`=1 and `sel_ch`<16, begins a run. In the next cycle `rdy_sec`, `rdy_cmp`, `abort_flg` and `flt_vec` are all 0.
- R3: A `start` pulse while idle with `adc_run`=0, or with `sel_single`=0, or with `sel_ch`>=16 aborts. In the next cycle `abort_flg`, `rdy_sec` and `rdy_cmp` are 1 and `flt_vec` is all ones (0xFF in each byte).
- R4: On an abort with `sel_single`=1, `sec_cap` becomes 0x8000 in the next cycle. With `sel_single`=0, `sec_cap` keeps its value. `pri_cap` is unchanged by any abort.
- R5: Sample strobes on either path in the `settle_len`+1 cycles that follow the start cycle are never captured.
- R6: After settling, the block waits for a primary sample tagged slot 0 (`align_late`=0) or slot 7 (`align_late`=1). `sec_cap` takes the first secondary sample strobed in any later cycle.
- R7: `pri_cap` takes the first primary sample whose slot equals `sel_ch`, counted from the alignment sample itself. When `sel_ch` equals the alignment slot, that same sample is taken.
- R8: Primary samples tagged slot 16 or higher (slot 16 is current sense) are never captured, and `sel_ch`>=16 aborts as in R3.
- R9: Once both values are captured, `flt_vec` bit `sel_ch` is set exactly when |pri−sec| > `tol`, with both samples read as 16-bit two's complement and `tol` unsigned. Bit i belongs to channel i (bits 7:0 form the low fault byte, bits 15:8 the high byte). All other bits stay 0, and `rdy_cmp` then reads 1.
- R10: `rdy_sec` becomes 1 once the secondary value is captured. `rdy_cmp` is never 1 while `rdy_sec` is 0.
- R11: A `start` pulse during a run is ignored whatever the other inputs are: no abort is reported, and the run ends with the results of R6, R7 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a comparison |
| adc_run | input | 1 | Primary ADC is converting |
| sel_single | input | 1 | Secondary selector held on one channel |
| sel_ch | input | SLOT_W | Channel under test |
| align_late | input | 1 | 0: align to slot 0, 1: align to slot 7 |
| settle_len | input | SETTLE_W | Settling interval in cycles, minus one |
| tol | input | DW | Allowed magnitude of difference |
| pri_vld | input | 1 | Primary sample strobe |
| pri_slot | input | SLOT_W | Slot index of the primary sample |
| pri_smp | input | DW | Prefiltered primary sample |
| sec_vld | input | 1 | Secondary sample strobe |
| sec_smp | input | DW | Secondary sample |
| pri_cap | output | DW | Captured primary value |
| sec_cap | output | DW | Captured secondary value |
| flt_vec | output | NUM_CH | Per-channel fault bits |
| rdy_sec | output | 1 | Secondary value captured |
| rdy_cmp | output | 1 | Comparison result valid |
| abort_flg | output | 1 | Last start was rejected |

## Verification
Two events can fall in the same cycle: the alignment mark opening the capture window, and the primary capture for the chosen channel. This happens when `sel_ch` equals the alignment slot. Runs with channel 0 and default alignment, and with channel 7 and late alignment, provoke it. They pass only if `pri_cap` holds the alignment sample itself and not the same slot from the following frame. A second overlap, a new `start` landing mid-run, is injected while the primary ADC is reported stopped. It is judged by the absence of any abort pattern and by an intact final result.

// File: rtl/adc_xcheck_pkg.sv
package adc_xcheck_pkg;

   typedef enum logic [2:0] {
      XC_IDLE,
      XC_SETTLE,
      XC_ALIGN,
      XC_CAPT,
      XC_JUDGE
   } xc_state_e;

endpackage

// File: rtl/adc_xcheck_seq.sv
// Run sequencer: setup check on start, settle countdown, alignment mark.
module adc_xcheck_seq
   import adc_xcheck_pkg::*;
#(
   parameter int NUM_CH   = 16,
   parameter int SLOT_W   = 5,
   parameter int SETTLE_W = 10,
   parameter int ALIGN_LO = 0,
   parameter int ALIGN_HI = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                adc_run,
   input  logic                sel_single,
   input  logic [SLOT_W-1:0]   sel_ch,
   input  logic                align_late,
   input  logic [SETTLE_W-1:0] settle_len,
   input  logic                pri_vld,
   input  logic [SLOT_W-1:0]   pri_slot,
   input  logic                got_pri,
   input  logic                got_sec,
   output xc_state_e           st,
   output logic                launch,
   output logic                abort_p,
   output logic                open,
   output logic [SLOT_W-1:0]   ch_q
);

   localparam logic [SLOT_W-1:0] LO_SLOT = SLOT_W'(ALIGN_LO);
   localparam logic [SLOT_W-1:0] HI_SLOT = SLOT_W'(ALIGN_HI);
   localparam logic [SLOT_W-1:0] CH_LIM  = SLOT_W'(NUM_CH);

   logic [SETTLE_W-1:0] cnt;
   logic                align_q;
   logic                cfg_ok;
   logic [SLOT_W-1:0]   mark_slot;

   assign cfg_ok    = adc_run && sel_single && (sel_ch < CH_LIM);
   assign launch    = (st == XC_IDLE) && start && cfg_ok;
   assign abort_p   = (st == XC_IDLE) && start && !cfg_ok;
   assign mark_slot = align_q ? HI_SLOT : LO_SLOT;
   assign open      = (st == XC_ALIGN) && pri_vld && (pri_slot == mark_slot);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= XC_IDLE;
         cnt     <= '0;
         align_q <= 1'b0;
         ch_q    <= '0;
      end else begin
         case (st)
            XC_IDLE: begin
               if (launch) begin
                  st      <= XC_SETTLE;
                  cnt     <= settle_len;
                  align_q <= align_late;
                  ch_q    <= sel_ch;
               end
            end
            XC_SETTLE: begin
               if (cnt == '0) st <= XC_ALIGN;
               else           cnt <= cnt - 1'b1;
            end
            XC_ALIGN: begin
               if (open) st <= XC_CAPT;
            end
            XC_CAPT: begin
               if (got_pri && got_sec) st <= XC_JUDGE;
            end
            XC_JUDGE: st <= XC_IDLE;
            default:  st <= XC_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/adc_xcheck_cap.sv
// Capture gating: decides which strobe is taken on each path.
module adc_xcheck_cap
   import adc_xcheck_pkg::*;
#(
   parameter int SLOT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  xc_state_e         st,
   input  logic              launch,
   input  logic              open,
   input  logic [SLOT_W-1:0] ch_q,
   input  logic              pri_vld,
   input  logic [SLOT_W-1:0] pri_slot,
   input  logic              sec_vld,
   output logic              take_pri,
   output logic              take_sec,
   output logic              got_pri,
   output logic              got_sec
);

   logic in_capt;

   assign in_capt  = (st == XC_CAPT);
   assign take_pri = pri_vld && !got_pri && (pri_slot == ch_q) && (open || in_capt);
   assign take_sec = sec_vld && !got_sec && in_capt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         got_pri <= 1'b0;
         got_sec <= 1'b0;
      end else if (launch) begin
         got_pri <= 1'b0;
         got_sec <= 1'b0;
      end else begin
         got_pri <= got_pri | take_pri;
         got_sec <= got_sec | take_sec;
      end
   end

endmodule

// File: rtl/adc_xcheck_rslt.sv
// Result registers, tolerance judgement and abort pattern.
module adc_xcheck_rslt #(
   parameter int NUM_CH = 16,
   parameter int DW     = 16,
   parameter int SLOT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              abort_p,
   input  logic              sel_single,
   input  logic              take_pri,
   input  logic              take_sec,
   input  logic              judge,
   input  logic [SLOT_W-1:0] ch_q,
   input  logic [DW-1:0]     tol,
   input  logic [DW-1:0]     pri_smp,
   input  logic [DW-1:0]     sec_smp,
   output logic [DW-1:0]     pri_cap,
   output logic [DW-1:0]     sec_cap,
   output logic [NUM_CH-1:0] flt_vec,
   output logic              rdy_sec,
   output logic              rdy_cmp,
   output logic              abort_flg
);

   localparam logic [DW-1:0] EMPTY = {1'b1, {(DW-1){1'b0}}};

   logic [DW-1:0]     tol_q;
   logic signed [DW:0] diff;
   logic [DW:0]       mag;
   logic              over;
   logic [NUM_CH-1:0] hit;

   assign diff = $signed({pri_cap[DW-1], pri_cap}) - $signed({sec_cap[DW-1], sec_cap});
   assign mag  = diff[DW] ? $unsigned(-diff) : $unsigned(diff);
   assign over = mag > {1'b0, tol_q};

   for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
      assign hit[i] = (ch_q == SLOT_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tol_q     <= '0;
         pri_cap   <= EMPTY;
         sec_cap   <= EMPTY;
         flt_vec   <= '0;
         rdy_sec   <= 1'b0;
         rdy_cmp   <= 1'b0;
         abort_flg <= 1'b0;
      end else begin
         if (launch) tol_q <= tol;
         if (take_pri) pri_cap <= pri_smp;
         if (abort_p && sel_single) sec_cap <= EMPTY;
         else if (take_sec)         sec_cap <= sec_smp;

         if (launch) begin
            flt_vec   <= '0;
            rdy_sec   <= 1'b0;
            rdy_cmp   <= 1'b0;
            abort_flg <= 1'b0;
         end else if (abort_p) begin
            flt_vec   <= '1;
            rdy_sec   <= 1'b1;
            rdy_cmp   <= 1'b1;
            abort_flg <= 1'b1;
         end else begin
            if (take_sec) rdy_sec <= 1'b1;
            if (judge) begin
               flt_vec <= over ? hit : '0;
               rdy_cmp <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/adc_xcheck.sv
module adc_xcheck
   import adc_xcheck_pkg::*;
#(
   parameter int NUM_CH   = 16,
   parameter int DW       = 16,
   parameter int SLOT_W   = 5,
   parameter int SETTLE_W = 10,
   parameter int ALIGN_LO = 0,
   parameter int ALIGN_HI = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                adc_run,
   input  logic                sel_single,
   input  logic [SLOT_W-1:0]   sel_ch,
   input  logic                align_late,
   input  logic [SETTLE_W-1:0] settle_len,
   input  logic [DW-1:0]       tol,
   input  logic                pri_vld,
   input  logic [SLOT_W-1:0]   pri_slot,
   input  logic [DW-1:0]       pri_smp,
   input  logic                sec_vld,
   input  logic [DW-1:0]       sec_smp,
   output logic [DW-1:0]       pri_cap,
   output logic [DW-1:0]       sec_cap,
   output logic [NUM_CH-1:0]   flt_vec,
   output logic                rdy_sec,
   output logic                rdy_cmp,
   output logic                abort_flg
);

   if (NUM_CH % 8 != 0) begin : g_err_bytes
      $error("NUM_CH must fill whole fault bytes");
   end
   if (NUM_CH >= (1 << SLOT_W)) begin : g_err_slot
      $error("SLOT_W must leave room for out-of-range slots");
   end
   if (ALIGN_LO >= NUM_CH || ALIGN_HI >= NUM_CH) begin : g_err_align
      $error("alignment slots must be measurement channels");
   end
   if (DW < 2) begin : g_err_dw
      $error("DW too small");
   end

   xc_state_e         seq_st;
   logic              launch, abort_p, open;
   logic [SLOT_W-1:0] ch_q;
   logic              take_pri, take_sec, got_pri, got_sec;

   adc_xcheck_seq #(
      .NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .SETTLE_W(SETTLE_W),
      .ALIGN_LO(ALIGN_LO), .ALIGN_HI(ALIGN_HI)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .adc_run(adc_run),
      .sel_single(sel_single), .sel_ch(sel_ch), .align_late(align_late),
      .settle_len(settle_len), .pri_vld(pri_vld), .pri_slot(pri_slot),
      .got_pri(got_pri), .got_sec(got_sec), .st(seq_st), .launch(launch),
      .abort_p(abort_p), .open(open), .ch_q(ch_q)
   );

   adc_xcheck_cap #(.SLOT_W(SLOT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .st(seq_st), .launch(launch), .open(open),
      .ch_q(ch_q), .pri_vld(pri_vld), .pri_slot(pri_slot), .sec_vld(sec_vld),
      .take_pri(take_pri), .take_sec(take_sec), .got_pri(got_pri), .got_sec(got_sec)
   );

   adc_xcheck_rslt #(.NUM_CH(NUM_CH), .DW(DW), .SLOT_W(SLOT_W)) u_rslt (
      .clk(clk), .rst_n(rst_n), .launch(launch), .abort_p(abort_p),
      .sel_single(sel_single), .take_pri(take_pri), .take_sec(take_sec),
      .judge(seq_st == XC_JUDGE), .ch_q(ch_q), .tol(tol), .pri_smp(pri_smp),
      .sec_smp(sec_smp), .pri_cap(pri_cap), .sec_cap(sec_cap), .flt_vec(flt_vec),
      .rdy_sec(rdy_sec), .rdy_cmp(rdy_cmp), .abort_flg(abort_flg)
   );

endmodule

// File: rtl/adc_xcheck_chk.sv
module adc_xcheck_chk
   import adc_xcheck_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int DW     = 16,
   parameter int SLOT_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              adc_run,
   input logic              sel_single,
   input logic [SLOT_W-1:0] sel_ch,
   input logic              pri_vld,
   input logic [SLOT_W-1:0] pri_slot,
   input xc_state_e         st,
   input logic [DW-1:0]     pri_cap,
   input logic [DW-1:0]     sec_cap,
   input logic [NUM_CH-1:0] flt_vec,
   input logic              rdy_sec,
   input logic              rdy_cmp,
   input logic              abort_flg
);

   localparam logic [SLOT_W-1:0] CH_LIM = SLOT_W'(NUM_CH);
   localparam logic [DW-1:0]     EMPTY  = {1'b1, {(DW-1){1'b0}}};

   logic idle, good;
   assign idle = (st == XC_IDLE);
   assign good = adc_run && sel_single && (sel_ch < CH_LIM);

   a_r2_launch_clears: assert property (@(posedge clk) disable iff (!rst_n)
      idle && start && good |=> !rdy_sec && !rdy_cmp && !abort_flg && (flt_vec == '0));

   a_r3_abort_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      idle && start && !good |=> abort_flg && rdy_sec && rdy_cmp && (&flt_vec));

   a_r4_abort_empty: assert property (@(posedge clk) disable iff (!rst_n)
      idle && start && !good && sel_single |=> (sec_cap == EMPTY) && $stable(pri_cap));

   a_r4_abort_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      idle && start && !good && !sel_single |=> $stable(sec_cap) && $stable(pri_cap));

   a_r5_settle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st == XC_SETTLE) |=> $stable(pri_cap) && $stable(sec_cap));

   a_r8_no_cs_slot: assert property (@(posedge clk) disable iff (!rst_n)
      pri_vld && (pri_slot >= CH_LIM) && !idle |=> $stable(pri_cap));

   a_r9_single_fault: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_cmp && !abort_flg |-> $onehot0(flt_vec));

   a_r10_ready_order: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_cmp |-> rdy_sec);

   a_r11_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      !idle && start |=> !abort_flg);

endmodule

bind adc_xcheck adc_xcheck_chk #(.NUM_CH(NUM_CH), .DW(DW), .SLOT_W(SLOT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .adc_run(adc_run),
   .sel_single(sel_single), .sel_ch(sel_ch), .pri_vld(pri_vld),
   .pri_slot(pri_slot), .st(seq_st), .pri_cap(pri_cap), .sec_cap(sec_cap),
   .flt_vec(flt_vec), .rdy_sec(rdy_sec), .rdy_cmp(rdy_cmp), .abort_flg(abort_flg)
);

// File: tb/adc_xcheck_bench.sv
module adc_xcheck_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NUM_CH     = 16;
   localparam int DW         = 16;
   localparam int SLOT_W     = 5;
   localparam int SETTLE_W   = 10;
   localparam int FRAME      = 17;
   localparam logic [15:0] DECOY = 16'h7FFF;

   logic clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic                rst_n, start, adc_run, sel_single, align_late;
   logic [SLOT_W-1:0]   sel_ch, pri_slot;
   logic [SETTLE_W-1:0] settle_len;
   logic [DW-1:0]       tol, pri_smp, sec_smp, pri_cap, sec_cap;
   logic                pri_vld, sec_vld, rdy_sec, rdy_cmp, abort_flg;
   logic [NUM_CH-1:0]   flt_vec;

   adc_xcheck u_adc_xcheck (
      .clk(clk), .rst_n(rst_n), .start(start), .adc_run(adc_run),
      .sel_single(sel_single), .sel_ch(sel_ch), .align_late(align_late),
      .settle_len(settle_len), .tol(tol), .pri_vld(pri_vld), .pri_slot(pri_slot),
      .pri_smp(pri_smp), .sec_vld(sec_vld), .sec_smp(sec_smp), .pri_cap(pri_cap),
      .sec_cap(sec_cap), .flt_vec(flt_vec), .rdy_sec(rdy_sec), .rdy_cmp(rdy_cmp),
      .abort_flg(abort_flg)
   );

   int n_chk = 0;
   int n_err = 0;
   logic [15:0] pv [2][FRAME];
   logic [15:0] sv [2][FRAME];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit exp_fault(input logic [15:0] p, input logic [15:0] s, input logic [15:0] t);
      int d;
      d = int'($signed(p)) - int'($signed(s));
      if (d < 0) d = -d;
      return d > int'(t);
   endfunction

   task automatic fill_rand();
      for (int f = 0; f < 2; f++)
         for (int s = 0; s < FRAME; s++) begin
            pv[f][s] = 16'($urandom()) & 16'hBFFF;
            sv[f][s] = 16'($urandom()) & 16'hBFFF;
         end
   endtask

   task automatic fill_const(input logic [15:0] p, input logic [15:0] s);
      for (int f = 0; f < 2; f++)
         for (int s2 = 0; s2 < FRAME; s2++) begin
            pv[f][s2] = p;
            sv[f][s2] = s;
         end
   endtask

   task automatic run_ok(input int ch, input bit late, input int settle, input logic [15:0] t, input bit poke);
      logic [15:0] ep, es;
      logic [NUM_CH-1:0] ef;
      int a, fr;
      @(negedge clk);
      adc_run = 1'b1; sel_single = 1'b1; sel_ch = SLOT_W'(ch); align_late = late;
      settle_len = SETTLE_W'(settle); tol = t; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!rdy_sec && !rdy_cmp && !abort_flg && flt_vec == '0, "R2 launch clears flags",
          {rdy_sec, rdy_cmp, abort_flg, flt_vec}, 0);
      for (int k = 0; k <= settle; k++) begin
         pri_vld = 1'b1; pri_slot = SLOT_W'(ch); pri_smp = DECOY;
         sec_vld = 1'b1; sec_smp = DECOY;
         @(negedge clk);
      end
      for (int f = 0; f < 2; f++)
         for (int s = 0; s < FRAME; s++) begin
            pri_vld = 1'b1; pri_slot = SLOT_W'(s); pri_smp = pv[f][s];
            sec_vld = 1'b1; sec_smp = sv[f][s];
            if (poke && f == 0 && s == 3) begin start = 1'b1; adc_run = 1'b0; end
            else begin start = 1'b0; adc_run = 1'b1; end
            @(negedge clk);
         end
      pri_vld = 1'b0; sec_vld = 1'b0; start = 1'b0; adc_run = 1'b1;
      for (int w = 0; w < 30 && !rdy_cmp; w++) @(negedge clk);
      a  = late ? 7 : 0;
      fr = (ch >= a) ? 0 : 1;
      ep = pv[fr][ch];
      es = sv[0][a + 1];
      ef = exp_fault(ep, es, t) ? (NUM_CH'(1) << ch) : '0;
      chk(rdy_cmp && rdy_sec, "R10 ready flags after run", {rdy_sec, rdy_cmp}, 2'b11);
      chk(pri_cap != DECOY && sec_cap != DECOY, "R5 settle samples discarded", {pri_cap, sec_cap}, 0);
      chk(pri_cap == ep, "R7 primary capture", pri_cap, ep);
      chk(sec_cap == es, "R6 aligned secondary capture", sec_cap, es);
      chk(flt_vec == ef, "R9 fault vector", flt_vec, ef);
      if (poke) chk(!abort_flg, "R11 start during run ignored", abort_flg, 0);
   endtask

   task automatic run_abort(input bit adc, input bit single, input int ch);
      logic [15:0] pc0, sc0, esc;
      @(negedge clk);
      pc0 = pri_cap; sc0 = sec_cap;
      adc_run = adc; sel_single = single; sel_ch = SLOT_W'(ch); start = 1'b1;
      @(negedge clk);
      start = 1'b0; adc_run = 1'b1;
      esc = single ? 16'h8000 : sc0;
      chk(abort_flg && rdy_sec && rdy_cmp, "R3 abort flags", {abort_flg, rdy_sec, rdy_cmp}, 3'b111);
      chk(flt_vec == 16'hFFFF, "R3 abort fault bytes", flt_vec, 16'hFFFF);
      chk(sec_cap == esc && pri_cap == pc0, "R4 abort capture registers", {pri_cap, sec_cap}, {pc0, esc});
      if (ch >= NUM_CH) chk(abort_flg, "R8 out-of-range channel aborts", abort_flg, 1);
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
      $finish;
   end

   initial begin
      int seed;
      seed = int'($urandom(32'd20231));
      rst_n = 1'b0; start = 1'b0; adc_run = 1'b0; sel_single = 1'b0; align_late = 1'b0;
      sel_ch = '0; pri_slot = '0; settle_len = '0; tol = '0; pri_smp = '0; sec_smp = '0;
      pri_vld = 1'b0; sec_vld = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pri_cap == 16'h8000 && sec_cap == 16'h8000, "R1 reset captures", {pri_cap, sec_cap}, 32'h80008000);
      chk(flt_vec == '0 && !rdy_sec && !rdy_cmp && !abort_flg, "R1 reset flags",
          {flt_vec, rdy_sec, rdy_cmp, abort_flg}, 0);

      // alignment mark and primary capture in one cycle (channel 0, default alignment)
      fill_rand(); run_ok(0, 1'b0, 0, 16'h0100, 1'b0);
      run_abort(1'b0, 1'b1, 3);
      fill_rand(); run_ok(5, 1'b0, 2, 16'h2000, 1'b0);
      run_abort(1'b1, 1'b0, 4);
      run_abort(1'b1, 1'b1, 16);
      // tolerance boundary: difference of exactly 120
      fill_const(16'h0064, 16'hFFEC); run_ok(9, 1'b0, 1, 16'd120, 1'b0);
      fill_const(16'h0064, 16'hFFEC); run_ok(9, 1'b0, 1, 16'd119, 1'b0);
      fill_const(16'hFFEC, 16'h0064); run_ok(2, 1'b1, 3, 16'd119, 1'b0);
      // late alignment: earlier channel, same-slot channel, last channel with a mid-run start
      fill_rand(); run_ok(3, 1'b1, 4, 16'h1000, 1'b0);
      fill_rand(); run_ok(7, 1'b1, 0, 16'h1000, 1'b0);
      fill_rand(); run_ok(15, 1'b1, 3, 16'h4000, 1'b1);

      for (int i = 0; i < 40; i++) begin
         fill_rand();
         run_ok($urandom_range(15, 0), 1'($urandom_range(1, 0)), $urandom_range(20, 0),
                16'($urandom_range(40000, 0)), ($urandom_range(3, 0) == 0));
         if (i % 5 == 4) begin
            bit a_run, a_sgl;
            int a_ch;
            a_run = 1'($urandom_range(1, 0));
            a_sgl = 1'($urandom_range(1, 0));
            a_ch  = $urandom_range(20, 0);
            if (a_run && a_sgl && a_ch < NUM_CH) a_run = 1'b0;
            run_abort(a_run, a_sgl, a_ch);
         end
      end
      report();
      $finish;
   end

endmodule